// File: doc/BRIEF.md
# LCD Sync and Pixel-Window Generator

This block produces the timing skeleton for a 320x240 TFT panel that is fed over an 8-bit parallel bus. Each pixel takes several bus clock ticks, either two (16-bit colour) or three (24-bit colour). The block counts bus ticks within a line and ticks within a frame. From those counts it drives an active-low horizontal sync, an active-low vertical sync and a pixel-enable window. It also gives a one-tick marker at the start of each line and at the start of each frame. Once enabled, it runs frame after frame with no gap. A pixel formatter and a memory fetcher use the markers and the window to decide when bytes go onto the bus.

All horizontal timing is counted in bus ticks and scales with the number of ticks per pixel. The first data tick of a line is pushed later by a pipeline delay that depends on the colour format. A build parameter chooses one of two panel timing sets. The second set runs at three ticks per pixel whatever the colour input says. It holds a longer line, a much wider vertical sync, and a start order in which the vertical timer runs a few ticks ahead of the horizontal one.

Top module: `lcd_sync_gen`

## Requirements
- R1: While reset is low, and on every cycle after a clock edge that samples `en` low, `hs_n` and `vs_n` are 1, and `pix_en`, `line_start` and `frame_start` are 0. All counters return to zero.
- R2: With profile 0, the ticks-per-pixel count P is 2 when `rgb888`=0 and 3 when `rgb888`=1. With profile 1, P is 3 and `rgb888` has no effect. `rgb888` is changed only while `en` is low.
- R3: Line tick h counts 0 to L-1 and then wraps, where L = H_TOTAL_PIX*P for profile 0 and ALT_H_TOTAL_PIX*3 for profile 1. `hs_n` is 0 exactly while h < W_H, where W_H = H_SYNC_PIX*P for profile 0 and ALT_H_SYNC_TICKS for profile 1. `line_start` is 1 exactly at h = 0.
- R4: `pix_en` is 1 on a displayed line exactly for S <= h < S + H_ACTIVE_PIX*P. S = H_FRONT_PIX*P + D for profile 0, where D is DELAY_RGB565 when P=2 and DELAY_RGB888 when P=3. S = ALT_FIRST_TICK for profile 1.
- R5: A frame holds N = V_ACTIVE_LINES + B lines and lasts L*N ticks. B is V_BLANK_LINES for profile 0 and ALT_V_BLANK_LINES for profile 1. Frame tick f runs from 0 to L*N-1. `vs_n` is 0 exactly while f < W_V, where W_V = V_SYNC_PIX*P for profile 0 and ALT_V_SYNC_LINES*L for profile 1. `frame_start` is 1 exactly at f = 0.
- R6: Lines 0 to B-1 of the line count are blanking lines, and `pix_en` stays 0 on them.
- R7: Call the first cycle after the clock edge that first samples `en` high tick 0. The frame tick is 0 at tick 0. The line tick and line count start from 0 at tick G, where G is 0 for profile 0 and ALT_VS_LEAD (at least 1) for profile 1. Before tick G, `hs_n` is 1 and `line_start` and `pix_en` are 0.
- R8: While `en` stays high, frames repeat back to back with no idle tick, and the offset G between the two timers is kept.
- R9: Dropping `en` for as little as one cycle, at any point in a frame, restarts the whole sequence from tick 0 as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus tick clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| en | input | 1 | Run request; low holds all timers at zero |
| rgb888 | input | 1 | Colour format: 0 = 16-bit (2 ticks/pixel), 1 = 24-bit (3 ticks/pixel); static while running |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| pix_en | output | 1 | High on ticks that carry pixel bytes |
| line_start | output | 1 | One-tick marker at line tick 0 |
| frame_start | output | 1 | One-tick marker at frame tick 0 |

## Verification
The hardest cases to reach are the offset between the vertical and horizontal timers, and the way that offset carries across a frame wrap. In profile 1 the line count wraps G ticks after the vertical sync falls, and an error of one cycle in the start sequencer shifts every later edge. A second one is a restart from the middle of a frame. The bench shrinks the panel to a few pixels and lines, so that whole frames last only a few hundred ticks. It runs one instance of each profile for several complete frames, drops and raises `en` mid-frame, and compares every output on every tick against a model that works from the tick index since enable.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  localparam int unsigned TICK_W  = 16;
  localparam int unsigned LINE_W  = 10;
  localparam int unsigned FRAME_W = 24;

  typedef struct packed {
    logic [TICK_W-1:0]  line_ticks;
    logic [TICK_W-1:0]  hs_ticks;
    logic [TICK_W-1:0]  first_tick;
    logic [TICK_W-1:0]  data_ticks;
    logic [LINE_W-1:0]  lines;
    logic [LINE_W-1:0]  blank_lines;
    logic [FRAME_W-1:0] frame_ticks;
    logic [FRAME_W-1:0] vs_ticks;
  } lcd_timing_t;
endpackage

// File: rtl/lcd_wrap_counter.sv
module lcd_wrap_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] last,
  output logic [W-1:0] count,
  output logic         at_last
);
  assign at_last = (count == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      count <= '0;
    end else if (adv) begin
      count <= at_last ? '0 : count + W'(1);
    end
  end

  // R8: the counter wraps at its limit and never runs past it
  assert_count_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count <= last));
endmodule

// File: rtl/lcd_start_lag.sv
module lcd_start_lag #(
  parameter int unsigned LAG = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic v_on,
  output logic h_on
);
  localparam int unsigned CW = (LAG > 1) ? $clog2(LAG) : 1;

  logic h_go;

  generate
    if (LAG == 0) begin : g_together
      assign h_go = 1'b1;
    end else begin : g_staggered
      logic [CW-1:0] wait_cnt;

      always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
          wait_cnt <= '0;
        end else if (v_on && !h_on && !h_go) begin
          wait_cnt <= wait_cnt + CW'(1);
        end
      end

      assign h_go = v_on && (wait_cnt == CW'(LAG - 1));

      // R7: the horizontal timer only starts after the vertical one has run
      assert_vs_leads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_on) |-> $past(v_on));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      v_on <= 1'b0;
      h_on <= 1'b0;
    end else begin
      v_on <= 1'b1;
      if (!h_on && h_go) h_on <= 1'b1;
    end
  end

  // R7: the horizontal timer never runs without the vertical one
  assert_hs_after_vs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    h_on |-> v_on);
endmodule

// File: rtl/lcd_window_decode.sv
module lcd_window_decode import lcd_sync_pkg::*; (
  input  lcd_timing_t        tm,
  input  logic               v_on,
  input  logic               h_on,
  input  logic [FRAME_W-1:0] vcnt,
  input  logic [TICK_W-1:0]  hcnt,
  input  logic [LINE_W-1:0]  lcnt,
  output logic               hs_n,
  output logic               vs_n,
  output logic               pix_en,
  output logic               line_start,
  output logic               frame_start
);
  logic [TICK_W:0] win_end;
  logic            in_cols;
  logic            on_shown_line;

  always_comb begin
    win_end       = {1'b0, tm.first_tick} + {1'b0, tm.data_ticks};
    in_cols       = (hcnt >= tm.first_tick) && ({1'b0, hcnt} < win_end);
    on_shown_line = (lcnt >= tm.blank_lines);
    hs_n          = !(h_on && (hcnt < tm.hs_ticks));
    vs_n          = !(v_on && (vcnt < tm.vs_ticks));
    line_start    = h_on && (hcnt == '0);
    frame_start   = v_on && (vcnt == '0);
    pix_en        = h_on && on_shown_line && in_cols;
  end
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen import lcd_sync_pkg::*; #(
  parameter int unsigned PROFILE           = 0,
  parameter int unsigned H_TOTAL_PIX       = 336,
  parameter int unsigned H_ACTIVE_PIX      = 320,
  parameter int unsigned H_SYNC_PIX        = 2,
  parameter int unsigned H_FRONT_PIX       = 7,
  parameter int unsigned V_ACTIVE_LINES    = 240,
  parameter int unsigned V_BLANK_LINES     = 4,
  parameter int unsigned V_SYNC_PIX        = 2,
  parameter int unsigned DELAY_RGB565      = 3,
  parameter int unsigned DELAY_RGB888      = 5,
  parameter int unsigned ALT_H_TOTAL_PIX   = 408,
  parameter int unsigned ALT_H_SYNC_TICKS  = 90,
  parameter int unsigned ALT_FIRST_TICK    = 204,
  parameter int unsigned ALT_V_BLANK_LINES = 1,
  parameter int unsigned ALT_V_SYNC_LINES  = 3,
  parameter int unsigned ALT_VS_LEAD       = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rgb888,
  output logic hs_n,
  output logic vs_n,
  output logic pix_en,
  output logic line_start,
  output logic frame_start
);
  localparam int unsigned ALT_CPP = 3;
  localparam int unsigned VS_LEAD = (PROFILE == 1) ? ALT_VS_LEAD : 0;

  lcd_timing_t        tm;
  logic               v_on, h_on;
  logic [FRAME_W-1:0] vcnt;
  logic [TICK_W-1:0]  hcnt;
  logic [LINE_W-1:0]  lcnt;
  logic               v_wrap, h_wrap, l_wrap;

  always_comb begin
    int unsigned cpp;
    int unsigned blank;
    int unsigned lp;
    cpp   = (PROFILE == 1) ? ALT_CPP : (rgb888 ? 3 : 2);
    blank = (PROFILE == 1) ? ALT_V_BLANK_LINES : V_BLANK_LINES;
    lp    = (PROFILE == 1) ? ALT_H_TOTAL_PIX * ALT_CPP : H_TOTAL_PIX * cpp;
    tm.line_ticks  = TICK_W'(lp);
    tm.hs_ticks    = TICK_W'((PROFILE == 1) ? ALT_H_SYNC_TICKS : H_SYNC_PIX * cpp);
    tm.first_tick  = TICK_W'((PROFILE == 1) ? ALT_FIRST_TICK :
                     H_FRONT_PIX * cpp + (rgb888 ? DELAY_RGB888 : DELAY_RGB565));
    tm.data_ticks  = TICK_W'(H_ACTIVE_PIX * cpp);
    tm.lines       = LINE_W'(V_ACTIVE_LINES + blank);
    tm.blank_lines = LINE_W'(blank);
    tm.frame_ticks = FRAME_W'(lp * (V_ACTIVE_LINES + blank));
    tm.vs_ticks    = FRAME_W'((PROFILE == 1) ? ALT_V_SYNC_LINES * lp : V_SYNC_PIX * cpp);
  end

  lcd_start_lag #(.LAG(VS_LEAD)) lag_i (
    .clk(clk), .rst_n(rst_n), .en(en), .v_on(v_on), .h_on(h_on)
  );

  lcd_wrap_counter #(.W(FRAME_W)) frame_cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(!en), .adv(v_on),
    .last(tm.frame_ticks - FRAME_W'(1)), .count(vcnt), .at_last(v_wrap)
  );

  lcd_wrap_counter #(.W(TICK_W)) tick_cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(!en), .adv(h_on),
    .last(tm.line_ticks - TICK_W'(1)), .count(hcnt), .at_last(h_wrap)
  );

  lcd_wrap_counter #(.W(LINE_W)) line_cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(!en), .adv(h_on && h_wrap),
    .last(tm.lines - LINE_W'(1)), .count(lcnt), .at_last(l_wrap)
  );

  lcd_window_decode decode_i (
    .tm(tm), .v_on(v_on), .h_on(h_on), .vcnt(vcnt), .hcnt(hcnt), .lcnt(lcnt),
    .hs_n(hs_n), .vs_n(vs_n), .pix_en(pix_en),
    .line_start(line_start), .frame_start(frame_start)
  );

  // R1: one edge with en low leaves every output idle
  assert_idle_after_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hs_n && vs_n && !pix_en && !line_start && !frame_start));

  // R3: every falling edge of HS coincides with the line marker
  assert_line_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_n) |-> line_start);

  // R5: every falling edge of VS coincides with the frame marker
  assert_frame_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_n) |-> frame_start);

  // R6: the last line of a frame wraps the line count together with the line tick
  assert_line_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && h_on && h_wrap && l_wrap) |=> (en -> (lcnt == '0)));

  // R8: the frame counter wraps to zero after its last tick
  assert_frame_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && v_on && v_wrap) |=> (en -> frame_start));
endmodule

// File: tb/lcd_sync_gen_tb.sv
module lcd_sync_gen_tb_top;
  localparam int HT = 14, HA = 8, HSP = 2, HF = 3, VA = 5, VB = 2, VSP = 2;
  localparam int D565 = 3, D888 = 5;
  localparam int AHT = 14, AHS = 5, AST = 10, AVB = 1, AVSL = 3, ALAG = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_a = 1'b0, en_b = 1'b0, m_a = 1'b0, m_b = 1'b0;
  logic a_hs, a_vs, a_pix, a_ls, a_fs;
  logic b_hs, b_vs, b_pix, b_ls, b_fs;
  int   checks = 0, failures = 0, cur_k = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  lcd_sync_gen #(.PROFILE(0), .H_TOTAL_PIX(HT), .H_ACTIVE_PIX(HA), .H_SYNC_PIX(HSP),
    .H_FRONT_PIX(HF), .V_ACTIVE_LINES(VA), .V_BLANK_LINES(VB), .V_SYNC_PIX(VSP),
    .DELAY_RGB565(D565), .DELAY_RGB888(D888)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en_a), .rgb888(m_a), .hs_n(a_hs), .vs_n(a_vs),
    .pix_en(a_pix), .line_start(a_ls), .frame_start(a_fs));

  lcd_sync_gen #(.PROFILE(1), .H_ACTIVE_PIX(HA), .V_ACTIVE_LINES(VA),
    .ALT_H_TOTAL_PIX(AHT), .ALT_H_SYNC_TICKS(AHS), .ALT_FIRST_TICK(AST),
    .ALT_V_BLANK_LINES(AVB), .ALT_V_SYNC_LINES(AVSL), .ALT_VS_LEAD(ALAG)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .en(en_b), .rgb888(m_b), .hs_n(b_hs), .vs_n(b_vs),
    .pix_en(b_pix), .line_start(b_ls), .frame_start(b_fs));

  // returns {blank_line, vs_n, hs_n, pix_en, line_start, frame_start}
  function automatic logic [5:0] expect_out(input bit alt, input bit m888, input int k);
    int cpp, lp, hsw, st, win, blank, lines, fp, vsw, lag, vt, hk, ht, ln;
    logic vs_n, hs_n, pix, ls, fs, bl;
    cpp   = alt ? 3 : (m888 ? 3 : 2);
    lp    = alt ? AHT * 3 : HT * cpp;
    hsw   = alt ? AHS : HSP * cpp;
    st    = alt ? AST : HF * cpp + (m888 ? D888 : D565);
    win   = HA * cpp;
    blank = alt ? AVB : VB;
    lines = VA + blank;
    fp    = lp * lines;
    vsw   = alt ? AVSL * lp : VSP * cpp;
    lag   = alt ? ALAG : 0;
    vt    = k % fp;
    vs_n  = !(vt < vsw);
    fs    = (vt == 0);
    if (k < lag) begin
      hs_n = 1'b1; ls = 1'b0; pix = 1'b0; bl = 1'b0;
    end else begin
      hk   = k - lag;
      ht   = hk % lp;
      ln   = (hk / lp) % lines;
      bl   = (ln < blank);
      hs_n = !(ht < hsw);
      ls   = (ht == 0);
      pix  = !bl && (ht >= st) && (ht < st + win);
    end
    return {bl, vs_n, hs_n, pix, ls, fs};
  endfunction

  task automatic chk(input string tag, input string sig, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      if (failures < 30)
        $display("FAIL %s %s tick=%0d actual=%b expected=%b", tag, sig, cur_k, act, exp);
    end
  endtask

  task automatic check_idle(input bit alt);
    chk("R1", alt ? "alt hs_n" : "hs_n", alt ? b_hs : a_hs, 1'b1);
    chk("R1", alt ? "alt vs_n" : "vs_n", alt ? b_vs : a_vs, 1'b1);
    chk("R1", alt ? "alt pix_en" : "pix_en", alt ? b_pix : a_pix, 1'b0);
    chk("R1", alt ? "alt line_start" : "line_start", alt ? b_ls : a_ls, 1'b0);
    chk("R1", alt ? "alt frame_start" : "frame_start", alt ? b_fs : a_fs, 1'b0);
  endtask

  // call right after raising en at a falling edge
  task automatic run_ticks(input bit alt, input bit m888, input int n, input string pre);
    for (int k = 0; k < n; k++) begin
      logic [5:0] e;
      string ht, pt;
      @(negedge clk);
      cur_k = k;
      e  = expect_out(alt, m888, k);
      ht = (alt && k < ALAG) ? "R7" : "R3";
      pt = e[5] ? "R6" : "R4";
      chk({pre, " R5"}, "vs_n", alt ? b_vs : a_vs, e[4]);
      chk({pre, " ", ht}, "hs_n", alt ? b_hs : a_hs, e[3]);
      chk({pre, " ", pt}, "pix_en", alt ? b_pix : a_pix, e[2]);
      chk({pre, " ", ht}, "line_start", alt ? b_ls : a_ls, e[1]);
      chk({pre, " R5"}, "frame_start", alt ? b_fs : a_fs, e[0]);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_idle(1'b0);
    check_idle(1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle(1'b0);
    check_idle(1'b1);

    // profile 0, 2 ticks per pixel: two frames and part of a third (R8)
    en_a = 1'b1;
    run_ticks(1'b0, 1'b0, 2 * 196 + 50, "R8");
    en_a = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check_idle(1'b0);
    end

    // R2: 3 ticks per pixel, delay grows
    m_a  = 1'b1;
    en_a = 1'b1;
    run_ticks(1'b0, 1'b1, 2 * 294, "R2");

    // R9: single-cycle drop mid-frame restarts the sequence
    run_ticks(1'b0, 1'b1, 77, "R9");
    en_a = 1'b0;
    @(negedge clk);
    check_idle(1'b0);
    en_a = 1'b1;
    run_ticks(1'b0, 1'b1, 300, "R9");
    en_a = 1'b0;

    // R7: alternate profile, VS timer leads HS timer
    en_b = 1'b1;
    run_ticks(1'b1, 1'b0, 2 * 252 + 20, "R7");
    en_b = 1'b0;
    @(negedge clk);
    check_idle(1'b1);

    // R2: alternate profile ignores the colour input
    m_b  = 1'b1;
    en_b = 1'b1;
    run_ticks(1'b1, 1'b0, 300, "R2");
    en_b = 1'b0;
    @(negedge clk);
    check_idle(1'b1);
    check_idle(1'b0);

    finish_run();
  end
endmodule